// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a SIMD datapath stage that takes two packed source vectors and an accumulator vector. It multiplies groups of four narrow integer elements pairwise and adds each four-way sum into one wide accumulator lane. There are two element sizes. With 8-bit elements each 32-bit accumulator lane absorbs one group. With 16-bit elements each 64-bit accumulator lane absorbs one group. Elements can be treated as signed or as unsigned.

In vector form, lane i pairs the i-th group of the first source with the i-th group of the second source. In indexed form, one group of the second source is picked by an index and broadcast to every lane of the same 128-bit segment. The pick is made separately in each segment. The operation length is given in bytes. Accumulator bytes at or beyond that length come back as zero. The result is registered and is marked by an output valid one cycle after the input valid. Instruction decode and register files sit outside the block.

Top module: `dotp_acc_unit`

## Requirements
- R1: With elem_half_i=0, each 32-bit lane l of acc_o equals acc_i lane l plus the sum, for k=0..3, of the products of src_n_i byte 4l+k and the selected src_m_i byte, taken modulo 2^32.
- R2: With elem_half_i=1, each 64-bit lane l equals acc_i lane l plus the sum, for k=0..3, of the products of src_n_i halfword 4l+k and the selected src_m_i halfword, taken modulo 2^64.
- R3: With signed_i=1 the elements are sign-extended, and with signed_i=0 they are zero-extended. All-0x80 bytes give 0x00010000 per 32-bit lane when signed. All-0xFF bytes give 0x0003F804 unsigned and 4 signed. All-0x8000 halfwords give 0x1_0000_0000 signed. All-0xFFFF halfwords give 0x3_FFF8_0004 unsigned.
- R4: The accumulation wraps and never saturates. For example, 0x7FFFFFFF plus 64516 gives 0x8000FC03.
- R5: With indexed_i=1 and byte elements, every lane in 128-bit segment s uses src_m_i bytes 16s+4*index_i+0..3.
- R6: With indexed_i=1 and halfword elements, every lane in segment s uses src_m_i halfwords 8s+4*index_i[0]+0..3. index_i[1] has no effect.
- R7: With len_i=8, byte elements and indexed form, lanes 0 and 1 are computed from the group that the index names in segment 0, even when that group lies beyond byte 8. All other lanes are zero.
- R8: len_i is given in bytes and is one of 8, 16 or VEC_BYTES. Bytes of acc_o at positions len_i and above are zero.
- R9: valid_o is valid_i delayed by one cycle. acc_o is loaded on a cycle with valid_i=1 and holds its value on any cycle with valid_i=0.
- R10: While rst_ni is low, valid_o and acc_o are zero.
- R11: In halfword indexed form, every lane adds to its own acc_i lane. Results written to other lanes of the segment never feed back into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request this cycle |
| signed_i | input | 1 | 1: signed elements, 0: unsigned |
| elem_half_i | input | 1 | 0: 8-bit elements into 32-bit lanes, 1: 16-bit elements into 64-bit lanes |
| indexed_i | input | 1 | 1: broadcast one group of src_m_i per segment |
| index_i | input | 2 | Group select for indexed form |
| len_i | input | LEN_W | Operation length in bytes |
| src_n_i | input | VEC_BYTES*8 | First source vector |
| src_m_i | input | VEC_BYTES*8 | Second source vector |
| acc_i | input | VEC_BYTES*8 | Accumulator input |
| valid_o | output | 1 | Result valid |
| acc_o | output | VEC_BYTES*8 | Updated accumulator with tail cleared |

## Verification
The bench drives extreme operands in all four element positions: -128 squared, 255 squared, -1 as a signed byte, and the 16-bit equivalents. A design that extends elements the wrong way gives results that are off by a large power of two. A design that saturates instead of wrapping is caught when the accumulator is pushed past its top value. In indexed form the bench walks every index value in both element sizes, with data that differs per segment. A design that picks its group once for the whole vector, or that decodes index bit 1 for halfwords, gives a different sum in the upper segment. It also runs the 8-byte partial segment with an index that points past the length, and it checks the cleared tail for every length. A design that clears bytes by lane count rather than byte count leaves stale upper bytes.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int SEG_BYTES = 16;
  localparam int SEG_W     = SEG_BYTES * 8;
  localparam int SLICE_W   = 64;

  function automatic logic signed [8:0] ext8(input logic [7:0] v, input logic sgn);
    return {sgn & v[7], v};
  endfunction

  function automatic logic signed [16:0] ext16(input logic [15:0] v, input logic sgn);
    return {sgn & v[15], v};
  endfunction
endpackage

// File: rtl/dotp_operand_sel.sv
module dotp_operand_sel
  import dotp_pkg::*;
#(
  parameter int VEC_BYTES = 32,
  localparam int VW = VEC_BYTES * 8,
  localparam int N_SEG = VEC_BYTES / SEG_BYTES
) (
  input  logic          indexed_i,
  input  logic          half_i,
  input  logic [1:0]    index_i,
  input  logic [VW-1:0] m_i,
  output logic [VW-1:0] m_eff_o
);
  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg;
    logic [31:0]      word;
    logic [63:0]      dword;
    logic [SEG_W-1:0] bcast;

    assign seg   = m_i[s*SEG_W +: SEG_W];
    // per-segment pick; halfword form only honours index bit 0
    assign word  = seg[{index_i, 5'b0} +: 32];
    assign dword = seg[{index_i[0], 6'b0} +: 64];
    assign bcast = half_i ? {2{dword}} : {4{word}};
    assign m_eff_o[s*SEG_W +: SEG_W] = indexed_i ? bcast : seg;
  end
endmodule

// File: rtl/dotp_slice.sv
module dotp_slice
  import dotp_pkg::*;
(
  input  logic        sgn_i,
  input  logic        half_i,
  input  logic [63:0] n_i,
  input  logic [63:0] m_i,
  input  logic [63:0] acc_i,
  output logic [63:0] res_o
);
  logic signed [19:0] bsum [2];
  logic signed [35:0] hsum;
  logic [31:0]        bres [2];
  logic [63:0]        hres;

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      bsum[w] = '0;
      for (int k = 0; k < 4; k++) begin : b_prod
        logic signed [17:0] p;
        p = ext8(n_i[w*32 + k*8 +: 8], sgn_i) * ext8(m_i[w*32 + k*8 +: 8], sgn_i);
        bsum[w] = bsum[w] + 20'(p);
      end
    end
  end

  always_comb begin
    hsum = '0;
    for (int k = 0; k < 4; k++) begin : h_prod
      logic signed [33:0] p;
      p = ext16(n_i[k*16 +: 16], sgn_i) * ext16(m_i[k*16 +: 16], sgn_i);
      hsum = hsum + 36'(p);
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_blane
    assign bres[w] = acc_i[w*32 +: 32] + {{12{bsum[w][19]}}, bsum[w]};
  end
  assign hres  = acc_i + {{28{hsum[35]}}, hsum};
  assign res_o = half_i ? hres : {bres[1], bres[0]};

  // R1/R2: a zero first operand leaves the accumulator untouched
  always_comb begin
    if (n_i == '0) begin
      a_r1_zero_operand: assert (res_o == acc_i);
    end
  end
endmodule

// File: rtl/dotp_tail_mask.sv
module dotp_tail_mask #(
  parameter int VEC_BYTES = 32,
  parameter int LEN_W = 6,
  localparam int VW = VEC_BYTES * 8
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [VW-1:0]    d_i,
  output logic [VW-1:0]    d_o
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    assign d_o[b*8 +: 8] = (len_i > LEN_W'(b)) ? d_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/dotp_acc_unit.sv
module dotp_acc_unit
  import dotp_pkg::*;
#(
  parameter int VEC_BYTES = 32,
  localparam int VW = VEC_BYTES * 8,
  localparam int LEN_W = $clog2(VEC_BYTES) + 1,
  localparam int N_SLICE = VEC_BYTES / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             signed_i,
  input  logic             elem_half_i,
  input  logic             indexed_i,
  input  logic [1:0]       index_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [VW-1:0]    src_n_i,
  input  logic [VW-1:0]    src_m_i,
  input  logic [VW-1:0]    acc_i,
  output logic             valid_o,
  output logic [VW-1:0]    acc_o
);
  logic [VW-1:0] m_eff;
  logic [VW-1:0] raw;
  logic [VW-1:0] masked;

  dotp_operand_sel #(.VEC_BYTES(VEC_BYTES)) u_sel (
    .indexed_i(indexed_i),
    .half_i   (elem_half_i),
    .index_i  (index_i),
    .m_i      (src_m_i),
    .m_eff_o  (m_eff)
  );

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    dotp_slice u_slice (
      .sgn_i (signed_i),
      .half_i(elem_half_i),
      .n_i   (src_n_i[i*SLICE_W +: SLICE_W]),
      .m_i   (m_eff[i*SLICE_W +: SLICE_W]),
      .acc_i (acc_i[i*SLICE_W +: SLICE_W]),
      .res_o (raw[i*SLICE_W +: SLICE_W])
    );
  end

  dotp_tail_mask #(.VEC_BYTES(VEC_BYTES), .LEN_W(LEN_W)) u_mask (
    .len_i(len_i),
    .d_i  (raw),
    .d_o  (masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      acc_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) acc_o <= masked;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_o));
  a_r8_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((acc_o >> {$past(len_i), 3'b000}) == '0));
endmodule

// File: tb/tb_dotp_acc_unit.sv
module tb_dotp_acc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_BYTES = 32;
  localparam int VW = VEC_BYTES * 8;
  localparam int LEN_W = $clog2(VEC_BYTES) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic             signed_i = 1'b0;
  logic             half_i = 1'b0;
  logic             indexed_i = 1'b0;
  logic [1:0]       index_i = '0;
  logic [LEN_W-1:0] len_i = LEN_W'(VEC_BYTES);
  logic [VW-1:0]    n_i = '0, m_i = '0, acc_i = '0;
  logic             valid_o;
  logic [VW-1:0]    acc_o;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dotp_acc_unit #(.VEC_BYTES(VEC_BYTES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .signed_i(signed_i),
    .elem_half_i(half_i), .indexed_i(indexed_i), .index_i(index_i), .len_i(len_i),
    .src_n_i(n_i), .src_m_i(m_i), .acc_i(acc_i), .valid_o(valid_o), .acc_o(acc_o)
  );

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // reference model written from the requirements
  function automatic logic [VW-1:0] model(input logic [VW-1:0] n, m, acc,
      input logic sgn, hw, ixm, input logic [1:0] idx, input int len);
    logic [VW-1:0] r = '0;
    if (!hw) begin
      for (int l = 0; l < VEC_BYTES/4; l++) begin
        if (l*4 < len) begin
          logic [63:0] sum = '0;
          for (int k = 0; k < 4; k++) begin
            int mi = ixm ? (l/4)*16 + int'(idx)*4 + k : 4*l + k;
            logic [7:0] a = n[(4*l+k)*8 +: 8];
            logic [7:0] b = m[mi*8 +: 8];
            logic [63:0] ea = sgn ? {{56{a[7]}}, a} : {56'b0, a};
            logic [63:0] eb = sgn ? {{56{b[7]}}, b} : {56'b0, b};
            sum = sum + ea * eb;
          end
          r[l*32 +: 32] = acc[l*32 +: 32] + sum[31:0];
        end
      end
    end else begin
      for (int l = 0; l < VEC_BYTES/8; l++) begin
        if (l*8 < len) begin
          logic [63:0] sum = '0;
          for (int k = 0; k < 4; k++) begin
            int mi = ixm ? (l/2)*8 + int'(idx[0])*4 + k : 4*l + k;
            logic [15:0] a = n[(4*l+k)*16 +: 16];
            logic [15:0] b = m[mi*16 +: 16];
            logic [63:0] ea = sgn ? {{48{a[15]}}, a} : {48'b0, a};
            logic [63:0] eb = sgn ? {{48{b[15]}}, b} : {48'b0, b};
            sum = sum + ea * eb;
          end
          r[l*64 +: 64] = acc[l*64 +: 64] + sum;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [VW-1:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive one operation, sample after the capturing edge
  task automatic apply(input string req, input logic [VW-1:0] n, m, acc,
      input logic sgn, hw, ixm, input logic [1:0] idx, input int len,
      input logic [VW-1:0] exp);
    @(negedge clk);
    n_i = n; m_i = m; acc_i = acc; signed_i = sgn; half_i = hw;
    indexed_i = ixm; index_i = idx; len_i = LEN_W'(len); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, acc_o, exp);
    check({req, " valid"}, VW'(valid_o), VW'(1));
  endtask

  task automatic run_model(input string req, input logic sgn, hw, ixm,
      input logic [1:0] idx, input int len);
    logic [VW-1:0] n = rnd_vec(), m = rnd_vec(), a = rnd_vec();
    apply(req, n, m, a, sgn, hw, ixm, idx, len, model(n, m, a, sgn, hw, ixm, idx, len));
  endtask

  task automatic t_reset();
    check("R10 acc", acc_o, '0);
    check("R10 valid", VW'(valid_o), '0);
  endtask

  task automatic t_byte_vec();
    for (int i = 0; i < 4; i++) run_model("R1 byte vector", i[0], 1'b0, 1'b0, 2'd0, VEC_BYTES);
  endtask

  task automatic t_half_vec();
    for (int i = 0; i < 4; i++) run_model("R2 half vector", i[0], 1'b1, 1'b0, 2'd0, VEC_BYTES);
  endtask

  task automatic t_extremes();
    apply("R3 signed -128^2", {VEC_BYTES{8'h80}}, {VEC_BYTES{8'h80}}, '0,
          1'b1, 1'b0, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/4){32'h0001_0000}});
    apply("R3 unsigned 255^2", {VEC_BYTES{8'hFF}}, {VEC_BYTES{8'hFF}}, '0,
          1'b0, 1'b0, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/4){32'h0003_F804}});
    apply("R3 signed -1^2", {VEC_BYTES{8'hFF}}, {VEC_BYTES{8'hFF}}, '0,
          1'b1, 1'b0, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/4){32'h0000_0004}});
    apply("R3 half signed min", {(VEC_BYTES/2){16'h8000}}, {(VEC_BYTES/2){16'h8000}}, '0,
          1'b1, 1'b1, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/8){64'h1_0000_0000}});
    apply("R3 half unsigned max", {(VEC_BYTES/2){16'hFFFF}}, {(VEC_BYTES/2){16'hFFFF}}, '0,
          1'b0, 1'b1, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/8){64'h3_FFF8_0004}});
  endtask

  task automatic t_wrap();
    apply("R4 wrap 32", {VEC_BYTES{8'h7F}}, {VEC_BYTES{8'h7F}}, {(VEC_BYTES/4){32'h7FFF_FFFF}},
          1'b1, 1'b0, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/4){32'h8000_FC03}});
    apply("R4 wrap 32 top", {VEC_BYTES{8'hFF}}, {VEC_BYTES{8'hFF}}, {VW{1'b1}},
          1'b1, 1'b0, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/4){32'h0000_0003}});
    apply("R4 wrap 64", {(VEC_BYTES/2){16'hFFFF}}, {(VEC_BYTES/2){16'hFFFF}}, {VW{1'b1}},
          1'b1, 1'b1, 1'b0, 2'd0, VEC_BYTES, {(VEC_BYTES/8){64'h3}});
  endtask

  task automatic t_idx_byte();
    logic [VW-1:0] m = '0, exp = '0;
    for (int i = 0; i < 4; i++) begin
      run_model("R5 byte indexed signed", 1'b1, 1'b0, 1'b1, 2'(i), VEC_BYTES);
      run_model("R5 byte indexed unsigned", 1'b0, 1'b0, 1'b1, 2'(i), VEC_BYTES);
    end
    // index 2: segment 0 group bytes 8..11 = 1, segment 1 group bytes 24..27 = 3
    m[8*8 +: 32] = 32'h0101_0101;
    m[24*8 +: 32] = 32'h0303_0303;
    for (int l = 0; l < VEC_BYTES/4; l++) exp[l*32 +: 32] = (l < 4) ? 32'd4 : 32'd12;
    apply("R5 per-segment group", {VEC_BYTES{8'h01}}, m, '0, 1'b0, 1'b0, 1'b1, 2'd2,
          VEC_BYTES, exp);
  endtask

  task automatic t_idx_half();
    logic [VW-1:0] n = rnd_vec(), m = rnd_vec(), a = rnd_vec();
    for (int i = 0; i < 4; i++)
      run_model("R6 half indexed", i[1], 1'b1, 1'b1, 2'(i), VEC_BYTES);
    apply("R6 index bit1 ignored", n, m, a, 1'b1, 1'b1, 1'b1, 2'd3, VEC_BYTES,
          model(n, m, a, 1'b1, 1'b1, 1'b1, 2'd1, VEC_BYTES));
  endtask

  task automatic t_len8();
    for (int i = 0; i < 4; i++) run_model("R7 len8 indexed", 1'b1, 1'b0, 1'b1, 2'(i), 8);
  endtask

  task automatic t_tail();
    run_model("R8 byte len16", 1'b0, 1'b0, 1'b0, 2'd0, 16);
    run_model("R8 half len16", 1'b1, 1'b1, 1'b0, 2'd0, 16);
    run_model("R8 half len8", 1'b0, 1'b1, 1'b0, 2'd0, 8);
    run_model("R8 byte len8 vector", 1'b1, 1'b0, 1'b0, 2'd0, 8);
  endtask

  task automatic t_distinct_acc();
    logic [VW-1:0] n = rnd_vec(), m = rnd_vec(), a = '0;
    for (int l = 0; l < VEC_BYTES/8; l++) a[l*64 +: 64] = 64'(l + 1) << (l * 8);
    apply("R11 own accumulator", n, m, a, 1'b1, 1'b1, 1'b1, 2'd0, VEC_BYTES,
          model(n, m, a, 1'b1, 1'b1, 1'b1, 2'd0, VEC_BYTES));
  endtask

  task automatic t_hold();
    logic [VW-1:0] n = rnd_vec(), m = rnd_vec(), a = rnd_vec();
    logic [VW-1:0] exp = model(n, m, a, 1'b0, 1'b0, 1'b0, 2'd0, VEC_BYTES);
    apply("R9 load", n, m, a, 1'b0, 1'b0, 1'b0, 2'd0, VEC_BYTES, exp);
    for (int i = 0; i < 3; i++) begin
      n_i = rnd_vec(); acc_i = rnd_vec();
      @(negedge clk);
      check("R9 hold", acc_o, exp);
      check("R9 valid low", VW'(valid_o), '0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired got=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_vec();
    t_half_vec();
    t_extremes();
    t_wrap();
    t_idx_byte();
    t_idx_half();
    t_len8();
    t_tail();
    t_distinct_acc();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule